// File: doc/BRIEF.md
# Four-Mode Register With Complement

This block is a small clocked register whose next contents come from one of four operations, picked by a two-bit mode select. It can keep its value, invert every bit in place, clear itself to zero, or take a new word from a parallel data bus. All four operations take effect only at the rising clock edge. Between edges, the select and data inputs are free to change.

Each bit position has its own four-way next-state selector, which feeds a single D storage element. The selector can be built in two ways, chosen by a parameter: as a case-style multiplexer, or as a decoded AND-OR network. Both build the same function. An active-low asynchronous reset forces the contents to all zeros whatever the select holds. Typical uses are as a control word that software-side logic can flip, wipe or overwrite in one cycle, or as the state holder in a simple test-pattern generator.

Top module: `quad_mode_reg`

## Requirements
- R1: While `rst_n` is low, `reg_out` is all zeros. It goes to zero without waiting for a clock edge and stays there across edges whatever `mode_sel` and `par_in` hold.
- R2: With `mode_sel` = 2'b00 at a rising edge, `reg_out` keeps its previous value.
- R3: With `mode_sel` = 2'b01 at a rising edge, every bit of `reg_out` becomes the inverse of its previous value.
- R4: With `mode_sel` = 2'b10, `reg_out` becomes all zeros at the rising edge and not before it.
- R5: With `mode_sel` = 2'b11 at a rising edge, `reg_out` takes the value on `par_in`.
- R6: Two consecutive edges with `mode_sel` = 2'b01 return `reg_out` to the value it had before the first of them.
- R7: `mode_sel` and `par_in` are sampled only at the rising edge. Changing them between edges leaves `reg_out` unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low, clears the contents |
| mode_sel | input | 2 | Operation: 00 keep, 01 invert, 10 clear, 11 load |
| par_in | input | WIDTH (4) | Parallel data taken in load mode |
| reg_out | output | WIDTH (4) | Current register contents |

## Verification
Two cases are hard to reach from the ports. The first is the difference between a clear applied at the edge and one that acts at once. The second is the guarantee that activity between edges is ignored. Both show up only when the output is observed in the middle of a cycle. The bench therefore sets the clear or load mode, or flips select and data several times, a few nanoseconds after an edge. It reads `reg_out` before the next edge and again after it. The reset case works the same way: reset is pulled low mid-cycle on a non-zero value, and the output is checked before any edge arrives.

// File: rtl/qmr_pkg.sv
package qmr_pkg;

   // Operation codes carried on the mode select input.
   typedef enum logic [1:0] {
      QMR_KEEP = 2'b00,
      QMR_FLIP = 2'b01,
      QMR_ZERO = 2'b10,
      QMR_TAKE = 2'b11
   } qmr_mode_e;

   localparam int QMR_MODE_BITS = 2;
   localparam int QMR_NUM_MODES = 1 << QMR_MODE_BITS;

   // Selector build variants.
   localparam int QMR_MUX_CASE  = 0;
   localparam int QMR_MUX_ANDOR = 1;

endpackage

// File: rtl/qmr_mode_decode.sv
module qmr_mode_decode
   import qmr_pkg::*;
(
   input  logic [QMR_MODE_BITS-1:0] mode_sel,
   output logic [QMR_NUM_MODES-1:0] mode_hot
);

   for (genvar k = 0; k < QMR_NUM_MODES; k++) begin : g_hot
      assign mode_hot[k] = (mode_sel == QMR_MODE_BITS'(k));
   end

   // Exactly one operation is selected for every select value.
   always_comb begin
      a_r2_one_mode: assert ($countones(mode_hot) == 1)
         else $error("mode decode is not one-hot");
   end

endmodule

// File: rtl/qmr_bit_select.sv
module qmr_bit_select
   import qmr_pkg::*;
#(
   parameter int MUX_IMPL = QMR_MUX_CASE
) (
   input  logic [QMR_MODE_BITS-1:0] mode_sel,
   input  logic                     cur_bit,
   input  logic                     new_bit,
   output logic                     next_bit
);

   if (MUX_IMPL == QMR_MUX_CASE) begin : g_case
      always_comb begin
         unique case (mode_sel)
            QMR_KEEP: next_bit = cur_bit;
            QMR_FLIP: next_bit = ~cur_bit;
            QMR_ZERO: next_bit = 1'b0;
            QMR_TAKE: next_bit = new_bit;
            default:  next_bit = cur_bit;
         endcase
      end
   end else if (MUX_IMPL == QMR_MUX_ANDOR) begin : g_andor
      logic [QMR_NUM_MODES-1:0] hot;

      qmr_mode_decode u_dec (
         .mode_sel (mode_sel),
         .mode_hot (hot)
      );

      // The clear term contributes nothing, so its line is left out of the OR.
      assign next_bit = (hot[QMR_KEEP] &  cur_bit)
                      | (hot[QMR_FLIP] & ~cur_bit)
                      | (hot[QMR_TAKE] &  new_bit);
   end else begin : g_bad_impl
      $error("qmr_bit_select: MUX_IMPL must be 0 or 1");
   end

endmodule

// File: rtl/qmr_bit_store.sv
module qmr_bit_store (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
   end

   // Held at zero through every edge that sees reset low.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_zero: assert (q == 1'b0)
            else $error("bit store not cleared under reset");
      end
   end

endmodule

// File: rtl/quad_mode_reg.sv
module quad_mode_reg
   import qmr_pkg::*;
#(
   parameter int WIDTH    = 4,
   parameter int MUX_IMPL = QMR_MUX_CASE
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [QMR_MODE_BITS-1:0] mode_sel,
   input  logic [WIDTH-1:0]         par_in,
   output logic [WIDTH-1:0]         reg_out
);

   localparam int MSB = WIDTH - 1;

   if (WIDTH < 1) begin : g_bad_width
      $error("quad_mode_reg: WIDTH must be at least 1");
   end
   if (MUX_IMPL != QMR_MUX_CASE && MUX_IMPL != QMR_MUX_ANDOR) begin : g_bad_mux
      $error("quad_mode_reg: unknown MUX_IMPL");
   end

   logic [MSB:0] next_word;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      qmr_bit_select #(.MUX_IMPL(MUX_IMPL)) u_sel (
         .mode_sel (mode_sel),
         .cur_bit  (reg_out[i]),
         .new_bit  (par_in[i]),
         .next_bit (next_word[i])
      );

      qmr_bit_store u_ff (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (next_word[i]),
         .q     (reg_out[i])
      );
   end

   // Behaviour of each operation, seen at the ports.
   a_r2_keep: assert property (@(posedge clk) disable iff (!rst_n)
      mode_sel == QMR_KEEP |=> reg_out == $past(reg_out))
      else $error("keep mode changed the contents");

   a_r3_flip: assert property (@(posedge clk) disable iff (!rst_n)
      mode_sel == QMR_FLIP |=> reg_out == ~$past(reg_out))
      else $error("flip mode did not invert");

   a_r4_zero: assert property (@(posedge clk) disable iff (!rst_n)
      mode_sel == QMR_ZERO |=> reg_out == '0)
      else $error("clear mode left bits set");

   a_r5_take: assert property (@(posedge clk) disable iff (!rst_n)
      mode_sel == QMR_TAKE |=> reg_out == $past(par_in))
      else $error("load mode did not capture data");

   a_r6_flip_twice: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == QMR_FLIP && $past(mode_sel) == QMR_FLIP && $past(rst_n))
      |=> reg_out == $past(reg_out, 2))
      else $error("double flip did not restore value");

endmodule

// File: tb/tb_quad_mode_reg.sv
module tb_quad_mode_reg;

   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic [1:0] mode_sel = 2'b00;
   logic [3:0] par_in = 4'h0;
   logic [3:0] reg_out;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   quad_mode_reg dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_sel (mode_sel),
      .par_in   (par_in),
      .reg_out  (reg_out)
   );

   always #5 clk = ~clk;

   task automatic check(string req, logic [3:0] got, logic [3:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: reg_out=%h expected=%h at %0t", req, got, exp, $time);
      end
   endtask

   // Wait for the next rising edge, then move 2 ns past it.
   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic load_word(logic [3:0] v);
      mode_sel = 2'b11;
      par_in   = v;
      tick();
   endtask

   task automatic t_reset();
      // R1: reset is low before the first edge.
      #2 rst_n = 1'b0;
      mode_sel = 2'b11; par_in = 4'hF;
      tick();
      check("R1 reset start", reg_out, 4'h0);
      tick();
      check("R1 reset across edge", reg_out, 4'h0);
      rst_n = 1'b1;
      load_word(4'hB);
      check("R5 load after reset", reg_out, 4'hB);
      // R1: reset asserted mid-cycle clears without an edge.
      #1 rst_n = 1'b0;
      #1 check("R1 async clear", reg_out, 4'h0);
      tick();
      check("R1 held under load", reg_out, 4'h0);
      rst_n = 1'b1;
   endtask

   task automatic t_keep();
      foreach (patterns[j]) begin
         load_word(patterns[j]);
         mode_sel = 2'b00; par_in = ~patterns[j];
         tick(); tick();
         check("R2 keep", reg_out, patterns[j]);
      end
   endtask

   task automatic t_flip();
      foreach (patterns[j]) begin
         load_word(patterns[j]);
         mode_sel = 2'b01;
         tick();
         check("R3 flip", reg_out, ~patterns[j]);
      end
   endtask

   task automatic t_zero();
      load_word(4'hD);
      mode_sel = 2'b10;
      #3 check("R4 no clear before edge", reg_out, 4'hD);
      tick();
      check("R4 clear at edge", reg_out, 4'h0);
      tick();
      check("R4 clear from zero", reg_out, 4'h0);
   endtask

   task automatic t_take();
      foreach (patterns[j]) begin
         load_word(patterns[j]);
         check("R5 load", reg_out, patterns[j]);
      end
   endtask

   task automatic t_flip_twice();
      foreach (patterns[j]) begin
         load_word(patterns[j]);
         mode_sel = 2'b01;
         tick();
         tick();
         check("R6 double flip", reg_out, patterns[j]);
         tick();
         check("R6 third flip", reg_out, ~patterns[j]);
      end
   endtask

   task automatic t_between_edges();
      load_word(4'h6);
      mode_sel = 2'b00;
      for (int k = 0; k < 4; k++) begin
         #1 mode_sel = 2'(k); par_in = 4'(k * 5 + 3);
      end
      #1 check("R7 mid-cycle activity", reg_out, 4'h6);
      mode_sel = 2'b00;
      tick();
      check("R7 keep after activity", reg_out, 4'h6);
   endtask

   logic [3:0] patterns [5] = '{4'h0, 4'hF, 4'hA, 4'h5, 4'h9};

   initial begin
      t_reset();
      t_keep();
      t_flip();
      t_zero();
      t_take();
      t_flip_twice();
      t_between_edges();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: reg_out=%h expected=finish", reg_out);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule